// File: doc/BRIEF.md
# Row-Scanned Serial Display Refresh Controller

This block keeps a 128 by 32 monochrome row-scanned panel refreshed from a frame buffer with no help from software. For each row it fetches the pixel words through a synchronous read port with a latency of one clock. It serializes the pixels onto a data line, with a dot clock whose rising edge the panel samples. It then blanks the panel drivers, pulses the column latch, steps the panel's row pointer with a row clock and switches the drivers back on for a programmed number of clocks. That on-time sets the brightness.

The scan repeats without end. While row N is shifted in, row N-1 is lit from the panel latch. A first-row marker is high while row 0 is loaded, so the panel's row counter is resynchronized once per frame on the falling edge of the row clock. Three configuration inputs set the dot clock half period, the latch and row clock pulse width, and the enable on-time. Two parameters set floors under the first two, so that the dot clock limit and the minimum pulse width of the panel hold even for a zero setting.

Top module: `scan_refresh`

## Requirements
- R1: Between two consecutive column latch pulses the dot clock has exactly 128 rising edges.
- R2: Word k of row r is read at frame-buffer address r*16+k, where the address is {row[4:0], word[3:0]}. Bit j of that word is column 8k+j. A 1 means lit. Column 0 is shifted first, so the panel image equals the frame buffer.
- R3: The column latch is low at every rising edge of the dot clock.
- R4: The driver enable is low in every cycle in which the column latch or the row clock changes level.
- R5: At each falling edge of the row clock the first-row marker is high exactly when row 0 is being latched. Rows advance 0 to 31 and wrap. Every row clock pulse is preceded by a column latch pulse of the same row.
- R6: Between consecutive row clock falling edges the driver enable is high for exactly cfg_on clocks. A value of 0 keeps the panel dark. An on-time longer than the shift stretches the row period and does not truncate the on-time.
- R7: The high and low phases of the dot clock within a row each last max(cfg_dot_half, MIN_DOT_HALF) clocks.
- R8: The latch and row clock high pulses each last P = max(cfg_pulse, MIN_PULSE) clocks. The enable is low for at least P clocks before the latch rises. The enable stays low for at least P clocks after the row clock falls.
- R9: After reset the enable, latch, row clock and dot clock are low and the marker is high. The first row shifted and latched is row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dot_half | input | TW | Dot clock half period in clocks |
| cfg_pulse | input | TW | Latch and row clock pulse width in clocks |
| cfg_on | input | ON_W | Driver on-time per row in clocks |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_addr | output | RW+WW | Frame-buffer word address {row, word} |
| fb_rd_data | input | WORD_W | Read data, valid one clock after the strobe |
| drv_en | output | 1 | Panel driver enable |
| sdata | output | 1 | Serial pixel data |
| dclk | output | 1 | Dot clock |
| lat | output | 1 | Column latch |
| rclk | output | 1 | Row clock |
| frame_mark | output | 1 | First-row marker |

## Verification
The hardest case to reach is an on-time longer than the shift of the next row. Here the controller finishes shifting while the drivers are still lit, and it must hold the latch until the enable has dropped. The bench reaches this case by programming an on-time of 600 clocks against a 256-clock shift. It then checks that each row still gets exactly that many enable clocks and that no latch or row clock edge falls inside the lit window. A second hard point is the marker wrap after row 31. To reach it, every scan runs 33 row clocks, so the marker is checked at both frame starts.

// File: rtl/scan_refresh.sv
module scan_refresh #(
  parameter int COLS         = 128,
  parameter int ROWS         = 32,
  parameter int WORD_W       = 8,
  parameter int TW           = 16,
  parameter int ON_W         = 20,
  parameter int MIN_DOT_HALF = 8,
  parameter int MIN_PULSE    = 125,
  localparam int WPR = COLS / WORD_W,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int WB  = $clog2(WORD_W),
  localparam int WW  = $clog2(WPR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     cfg_dot_half,
  input  logic [TW-1:0]     cfg_pulse,
  input  logic [ON_W-1:0]   cfg_on,
  output logic              fb_rd_en,
  output logic [RW+WW-1:0]  fb_addr,
  input  logic [WORD_W-1:0] fb_rd_data,
  output logic              drv_en,
  output logic              sdata,
  output logic              dclk,
  output logic              lat,
  output logic              rclk,
  output logic              frame_mark
);

  typedef enum logic [2:0] {F0, F1, SH, BL, LH, LL, RH, RL} st_t;

  localparam logic [TW-1:0] MDH = TW'(MIN_DOT_HALF);
  localparam logic [TW-1:0] MPW = TW'(MIN_PULSE);

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [CW-1:0]     col;
  logic [RW-1:0]     row;
  logic [WORD_W-1:0] sreg, nbuf;
  logic              pend;
  logic [ON_W-1:0]   on_cnt;
  logic              dclk_q;
  logic [WW-1:0]     fwd;

  wire [TW-1:0] dh       = (cfg_dot_half < MDH) ? MDH : cfg_dot_half;
  wire [TW-1:0] pw       = (cfg_pulse < MPW) ? MPW : cfg_pulse;
  wire          tdone    = (tmr == '0);
  wire          last_bit = (col[WB-1:0] == WB'(WORD_W - 1));
  wire [WW-1:0] cur_word = col[CW-1:WB];

  assign drv_en     = (on_cnt != '0);
  assign sdata      = sreg[0];
  assign dclk       = dclk_q;
  assign lat        = (st == LH);
  assign rclk       = (st == RH);
  assign frame_mark = (row == '0);
  assign fb_addr    = {row, fwd};

  always_comb begin
    fb_rd_en = 1'b0;
    fwd      = '0;
    case (st)
      F0: fb_rd_en = 1'b1;
      F1: begin fb_rd_en = 1'b1; fwd = WW'(1); end
      SH: if (dclk_q && tdone && last_bit && cur_word < WW'(WPR - 2)) begin
            fb_rd_en = 1'b1;
            fwd      = cur_word + WW'(2);
          end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= F0;
      tmr    <= '0;
      col    <= '0;
      row    <= '0;
      sreg   <= '0;
      nbuf   <= '0;
      pend   <= 1'b0;
      on_cnt <= '0;
      dclk_q <= 1'b0;
    end else begin
      pend <= fb_rd_en;
      if (pend && st != F1) nbuf <= fb_rd_data;
      if (on_cnt != '0) on_cnt <= on_cnt - 1'b1;
      case (st)
        F0: st <= F1;
        F1: begin
          sreg   <= fb_rd_data;
          col    <= '0;
          dclk_q <= 1'b0;
          tmr    <= dh - 1'b1;
          st     <= SH;
        end
        SH: begin
          if (!tdone) tmr <= tmr - 1'b1;
          else begin
            tmr <= dh - 1'b1;
            if (!dclk_q) dclk_q <= 1'b1;
            else begin
              dclk_q <= 1'b0;
              if (col == CW'(COLS - 1)) begin
                st  <= BL;
                tmr <= pw - 1'b1;
              end else begin
                col  <= col + 1'b1;
                sreg <= last_bit ? nbuf : (sreg >> 1);
              end
            end
          end
        end
        BL: if (on_cnt == '0) begin
          if (!tdone) tmr <= tmr - 1'b1;
          else begin tmr <= pw - 1'b1; st <= LH; end
        end
        LH: if (!tdone) tmr <= tmr - 1'b1; else begin tmr <= pw - 1'b1; st <= LL; end
        LL: if (!tdone) tmr <= tmr - 1'b1; else begin tmr <= pw - 1'b1; st <= RH; end
        RH: if (!tdone) tmr <= tmr - 1'b1; else begin tmr <= pw - 1'b1; st <= RL; end
        RL: if (!tdone) tmr <= tmr - 1'b1;
            else begin
              on_cnt <= cfg_on;
              row    <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
              st     <= F0;
            end
        default: st <= F0;
      endcase
    end
  end

  a_r3_lat_low_at_dclk: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> !lat);
  a_r4_lat_blank: assert property (@(posedge clk) disable iff (rst)
    (lat != $past(lat)) |-> !drv_en);
  a_r4_rclk_blank: assert property (@(posedge clk) disable iff (rst)
    (rclk != $past(rclk)) |-> !drv_en);
  a_r5_mark_steady: assert property (@(posedge clk) disable iff (rst)
    $fell(rclk) |-> $stable(frame_mark));
  a_r8_lat_after_dark: assert property (@(posedge clk) disable iff (rst)
    $rose(lat) |-> $past(!drv_en));
  a_r6_en_after_rclk: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> (!lat && !rclk && $past(st == RL)));

endmodule

// File: tb/sim_scan_refresh.sv
module sim_scan_refresh;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cfg_dot_half = 16'd1, cfg_pulse = 16'd4;
  logic [19:0] cfg_on = 20'd0;
  logic fb_rd_en;
  logic [8:0] fb_addr;
  logic [7:0] fb_rd_data = 8'h00;
  logic drv_en, sdata, dclk, lat, rclk, frame_mark;

  always #4 clk = ~clk;

  scan_refresh #(.MIN_DOT_HALF(1), .MIN_PULSE(4)) u0 (
    .clk(clk), .rst(rst), .cfg_dot_half(cfg_dot_half), .cfg_pulse(cfg_pulse),
    .cfg_on(cfg_on), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr),
    .fb_rd_data(fb_rd_data), .drv_en(drv_en), .sdata(sdata), .dclk(dclk),
    .lat(lat), .rclk(rclk), .frame_mark(frame_mark));

  logic [7:0] mem [0:511];
  always @(posedge clk) if (fb_rd_en) fb_rd_data <= mem[fb_addr];

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int exp_dh, exp_pw, exp_on;
  logic [127:0] sh, drv;
  logic [127:0] img [0:31];
  int ptr, rows_done, dots, hi_w, lo_w, lat_w, rc_w, en_hi, en_low, since_fall;
  bit ptr_ok, lat_seen, p_dclk, p_lat, p_rclk, p_en;

  always @(negedge clk) begin
    if (rst) begin
      rows_done = 0; ptr_ok = 0; ptr = 0; dots = 0; hi_w = 0; lo_w = 0;
      lat_w = 0; rc_w = 0; en_hi = 0; en_low = 0; since_fall = 0; lat_seen = 0;
      p_dclk = 0; p_lat = 0; p_rclk = 0; p_en = 0;
    end else begin
      if (dclk && !p_dclk) begin
        chk(!lat, "R3 latch at dot rise", lat, 0);
        if (dots != 0) chk(lo_w == exp_dh, "R7 dot low width", lo_w, exp_dh);
        sh = {sdata, sh[127:1]};
        dots++;
        hi_w = 0;
      end
      if (!dclk && p_dclk) begin
        chk(hi_w == exp_dh, "R7 dot high width", hi_w, exp_dh);
        lo_w = 0;
      end
      if (lat != p_lat) chk(!drv_en, "R4 enable at latch edge", drv_en, 0);
      if (rclk != p_rclk) chk(!drv_en, "R4 enable at row clock edge", drv_en, 0);
      if (lat && !p_lat) begin
        chk(dots == 128, "R1 dots per row", dots, 128);
        chk(en_low >= exp_pw, "R8 dark before latch", en_low, exp_pw);
        dots = 0; lat_w = 0;
      end
      if (!lat && p_lat) begin
        chk(lat_w == exp_pw, "R8 latch width", lat_w, exp_pw);
        drv = sh; lat_seen = 1;
      end
      if (rclk && !p_rclk) begin
        chk(lat_seen, "R5 latch before row clock", lat_seen, 1);
        rc_w = 0;
      end
      if (!rclk && p_rclk) begin
        chk(rc_w == exp_pw, "R8 row clock width", rc_w, exp_pw);
        chk(frame_mark == (ptr_ok ? (ptr == 31) : 1'b1), "R5 marker at row clock fall",
            frame_mark, ptr_ok ? (ptr == 31) : 1);
        if (rows_done != 0) chk(en_hi == exp_on, "R6 enable clocks per row", en_hi, exp_on);
        ptr = frame_mark ? 0 : ptr + 1;
        if (frame_mark) ptr_ok = 1;
        if (ptr_ok && ptr < 32) img[ptr] = drv;
        rows_done++; en_hi = 0; lat_seen = 0; since_fall = 0;
      end
      if (drv_en && !p_en) chk(since_fall >= exp_pw, "R8 dark after row clock", since_fall, exp_pw);
      if (dclk) hi_w++; else lo_w++;
      if (lat) lat_w++;
      if (rclk) rc_w++;
      if (drv_en) begin en_hi++; en_low = 0; end else en_low++;
      if (rclk) since_fall = 0; else since_fall++;
      p_dclk = dclk; p_lat = lat; p_rclk = rclk; p_en = drv_en;
    end
  end

  function automatic logic [7:0] pat(input int sel, input int a);
    case (sel)
      0: pat = 8'((a * 37 + 5) & 255);
      1: pat = ((a % 16) == ((a / 16) % 16)) ? (8'h01 << ((a / 16) % 8)) : 8'h00;
      2: pat = ~8'((a * 13) & 255);
      default: pat = 8'hA5 ^ 8'(a & 255);
    endcase
  endfunction

  task automatic run_scan(input int dh_cfg, input int pw_cfg, input int on_cfg, input int sel);
    logic [127:0] e;
    for (int a = 0; a < 512; a++) mem[a] = pat(sel, a);
    rst = 1;
    cfg_dot_half = 16'(dh_cfg); cfg_pulse = 16'(pw_cfg); cfg_on = 20'(on_cfg);
    exp_dh = (dh_cfg < 1) ? 1 : dh_cfg;
    exp_pw = (pw_cfg < 4) ? 4 : pw_cfg;
    exp_on = on_cfg;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: idle levels right after reset
    chk(!drv_en && !lat && !rclk && !dclk, "R9 outputs low after reset",
        {drv_en, lat, rclk, dclk}, 0);
    chk(frame_mark, "R9 marker high after reset", frame_mark, 1);
    while (rows_done < 1) @(negedge clk);
    chk(ptr_ok && ptr == 0, "R9 first row latched is row 0", ptr, 0);
    while (rows_done < 33) @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      for (int c = 0; c < 128; c++) e[c] = mem[r * 16 + c / 8][c % 8];
      chk(img[r] == e, $sformatf("R2 image row %0d", r), img[r], e);
    end
  endtask

  task automatic t_basic;      run_scan(1, 4, 100, 0); endtask
  task automatic t_dark_slow;  run_scan(3, 7, 0, 1);   endtask
  task automatic t_long_on;    run_scan(1, 2, 600, 2); endtask
  task automatic t_clamped;    run_scan(0, 0, 37, 3);  endtask

  initial begin
    t_basic;
    t_dark_slow;
    t_long_on;
    t_clamped;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule